// File: doc/BRIEF.md
# Bus Cycle Attribute Encoder

The encoder sits between a processor core and its external bus controller. For each bus transfer the core asks for, the encoder takes an access kind and the raw request fields. It produces the attribute set that the bus controller drives for the whole transfer: address, transfer type, transfer modifier, size, direction, the two user-attribute bits, cache-inhibit, lock and lock-end. Some kinds override the request fields with fixed encodings. Interrupt and breakpoint acknowledge cycles use fixed addresses, and cache pushes and line moves always use line size.

The core raises `req_valid` while the encoder is ready. The encoder then registers the attributes and raises `bus_req`. It holds every attribute steady until the bus controller returns `bus_ack`. The encoder also follows atomic read-modify-write sequences that the core opens and closes with two request flags. It asserts lock on each lockable transfer inside such a sequence, and it marks the closing transfer with lock-end.

Top module: `bus_attr_encoder`

## Requirements
- R1: While reset is active and after its release, `bus_req` is 0, `req_ready` is 1, and every attribute output is 0 until the first request is accepted.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. On the next cycle `bus_req` is 1 and `req_ready` is 0. All attribute outputs keep their values until the edge where `bus_ack` is seen with `bus_req` high. One cycle after that edge `bus_req` is 0, and request fields that change while `bus_req` is high have no effect. For the normal, push, table-search, line-move and alternate kinds, `bus_addr` equals the request address.
- R3: Access kind codes are: 0 normal, 1 cache push, 2 table search, 3 line move, 4 alternate space, 5 interrupt acknowledge, 6 breakpoint acknowledge, and 7 treated as normal. Transfer type is 0 for normal, push and table search, 1 for line move, 2 for alternate and 3 for both acknowledges.
- R4: Size codes are long 0, byte 1, word 2, line 3. A normal access uses the requested size, a table search uses long, and a line move uses line.
- R5: An alternate access drives the request modifier as transfer modifier, drives the requested direction and drives the requested size, except that a line request becomes long.
- R6: An interrupt acknowledge drives an all-ones address, byte size, read and the request modifier (the level, 1 to 7) as transfer modifier.
- R7: A breakpoint acknowledge drives address 0, byte size, read and transfer modifier 0, whatever the request fields hold.
- R8: A cache push drives write, line size, transfer modifier 0 and the request address, with lock, user bits and cache-inhibit at 0.
- R9: User-attribute bits and cache-inhibit are copied from the request for normal and line-move accesses and are 0 for every other kind.
- R10: Normal, table-search and line-move accesses drive the requested direction (`bus_write` 1 means write).
- R11: Only normal, table-search and alternate accesses are lockable. A lockable transfer asserts `bus_lock` when a sequence is open or `req_lock_start` is set. Push, line-move and acknowledge transfers never assert lock and leave the sequence state unchanged.
- R12: `bus_lock_end` is 1 only on a lockable transfer that asserts lock and has `req_lock_last` set, and such a transfer closes the sequence. A last flag on a transfer without lock is ignored.
- R13: Normal, table-search and line-move accesses drive the request modifier as transfer modifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests a transfer |
| req_ready | output | 1 | Encoder can accept a request |
| req_kind | input | 3 | Access kind code |
| req_addr | input | ADDR_W | Access address |
| req_size | input | 2 | Requested size code |
| req_write | input | 1 | Requested direction, 1 = write |
| req_mod | input | 3 | Modifier, function code or interrupt level |
| req_upa | input | 2 | Page user-attribute bits |
| req_cinh | input | 1 | Page cache-inhibit bit |
| req_lock_start | input | 1 | Transfer opens a locked sequence |
| req_lock_last | input | 1 | Transfer closes a locked sequence |
| bus_req | output | 1 | Transfer pending toward bus controller |
| bus_ack | input | 1 | Bus controller finished the transfer |
| bus_addr | output | ADDR_W | Transfer address |
| bus_tt | output | 2 | Transfer type |
| bus_tm | output | 3 | Transfer modifier |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | Direction, 1 = write |
| bus_lock | output | 1 | Locked transfer |
| bus_lock_end | output | 1 | Last transfer of a locked sequence |
| bus_upa | output | 2 | User-attribute bits |
| bus_cinh | output | 1 | Cache-inhibit |

## Verification
The properties assume that the bus controller raises `bus_ack` only while `bus_req` is high. They also use transfer type 3 with modifier 0 to mean a breakpoint acknowledge. For that to hold, an interrupt acknowledge must always carry a level from 1 to 7. The stimulus therefore drives acknowledges only while a transfer is pending, and it always draws interrupt levels from 1 to 7. Requests and their fields are also changed while the encoder is busy, and lock start and last flags are scattered over every kind, including kinds that must ignore them.

// File: rtl/bae_pkg.sv
package bae_pkg;

  typedef enum logic [2:0] {
    KIND_NORMAL = 3'd0,
    KIND_PUSH   = 3'd1,
    KIND_TABLE  = 3'd2,
    KIND_MOVE   = 3'd3,
    KIND_ALT    = 3'd4,
    KIND_IACK   = 3'd5,
    KIND_BKPT   = 3'd6,
    KIND_RSVD   = 3'd7
  } kind_e;

  localparam int SIZE_W = 2;
  localparam int TT_W   = 2;
  localparam int TM_W   = 3;
  localparam int UPA_W  = 2;

  localparam logic [SIZE_W-1:0] SZ_LONG = 2'd0;
  localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd1;
  localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;
  localparam logic [SIZE_W-1:0] SZ_LINE = 2'd3;

  localparam logic [TT_W-1:0] TT_PLAIN = 2'd0;
  localparam logic [TT_W-1:0] TT_MOVE  = 2'd1;
  localparam logic [TT_W-1:0] TT_ALT   = 2'd2;
  localparam logic [TT_W-1:0] TT_ACK   = 2'd3;

  // attributes derived from the access kind alone
  typedef struct packed {
    logic [TT_W-1:0]   tt;
    logic [TM_W-1:0]   tm;
    logic [SIZE_W-1:0] size;
    logic              write;
    logic [UPA_W-1:0]  upa;
    logic              cinh;
    logic              lockable;
  } map_t;

  // attributes presented on the bus
  typedef struct packed {
    logic [TT_W-1:0]   tt;
    logic [TM_W-1:0]   tm;
    logic [SIZE_W-1:0] size;
    logic              write;
    logic              lock;
    logic              lock_end;
    logic [UPA_W-1:0]  upa;
    logic              cinh;
  } out_t;

endpackage

// File: rtl/bae_attr_map.sv
module bae_attr_map
  import bae_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  kind_e              kind,
  input  logic [ADDR_W-1:0]  addr_in,
  input  logic [SIZE_W-1:0]  size_in,
  input  logic               write_in,
  input  logic [TM_W-1:0]    mod_in,
  input  logic [UPA_W-1:0]   upa_in,
  input  logic               cinh_in,
  output logic [ADDR_W-1:0]  addr_out,
  output map_t               attr
);

  localparam logic [ADDR_W-1:0] ADDR_ONES = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;

  always_comb begin
    addr_out      = addr_in;
    attr.tt       = TT_PLAIN;
    attr.tm       = mod_in;
    attr.size     = size_in;
    attr.write    = write_in;
    attr.upa      = '0;
    attr.cinh     = 1'b0;
    attr.lockable = 1'b0;
    unique case (kind)
      KIND_PUSH: begin
        attr.tm    = '0;
        attr.size  = SZ_LINE;
        attr.write = 1'b1;
      end
      KIND_TABLE: begin
        attr.size     = SZ_LONG;
        attr.lockable = 1'b1;
      end
      KIND_MOVE: begin
        attr.tt   = TT_MOVE;
        attr.size = SZ_LINE;
        attr.upa  = upa_in;
        attr.cinh = cinh_in;
      end
      KIND_ALT: begin
        attr.tt       = TT_ALT;
        attr.size     = (size_in == SZ_LINE) ? SZ_LONG : size_in;
        attr.lockable = 1'b1;
      end
      KIND_IACK: begin
        addr_out   = ADDR_ONES;
        attr.tt    = TT_ACK;
        attr.size  = SZ_BYTE;
        attr.write = 1'b0;
      end
      KIND_BKPT: begin
        addr_out   = ADDR_ZERO;
        attr.tt    = TT_ACK;
        attr.tm    = '0;
        attr.size  = SZ_BYTE;
        attr.write = 1'b0;
      end
      default: begin
        // normal and reserved code
        attr.upa      = upa_in;
        attr.cinh     = cinh_in;
        attr.lockable = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bae_lock_tracker.sv
module bae_lock_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic lockable,
  input  logic start,
  input  logic last,
  output logic lock,
  output logic lock_end
);

  logic open_q;
  logic open_d;
  logic open_en;

  always_comb begin
    lock     = lockable & (open_q | start);
    lock_end = lock & last;
    open_en  = take & lockable;
    open_d   = lock & ~last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (open_en) begin
      open_q <= open_d;
    end
  end

endmodule

// File: rtl/bae_hold_stage.sv
module bae_hold_stage
  import bae_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              ack,
  input  logic [ADDR_W-1:0] addr_in,
  input  out_t              attr_in,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_q,
  output out_t              attr_q
);

  logic busy_q;
  logic busy_d;
  logic load;

  always_comb begin
    busy_d = busy_q;
    load   = 1'b0;
    if (busy_q) begin
      if (ack) busy_d = 1'b0;
    end else if (take) begin
      busy_d = 1'b1;
      load   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      attr_q <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      attr_q <= attr_in;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/bus_attr_encoder.sv
module bus_attr_encoder
  import bae_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [2:0]        req_mod,
  input  logic [1:0]        req_upa,
  input  logic              req_cinh,
  input  logic              req_lock_start,
  input  logic              req_lock_last,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_tt,
  output logic [2:0]        bus_tm,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic              bus_lock,
  output logic              bus_lock_end,
  output logic [1:0]        bus_upa,
  output logic              bus_cinh
);

  logic              busy;
  logic              take;
  logic [ADDR_W-1:0] map_addr;
  map_t              map_attr;
  logic              lk_now;
  logic              lk_end_now;
  out_t              next_attr;
  out_t              held_attr;

  assign take      = req_valid & ~busy;
  assign req_ready = ~busy;

  bae_attr_map #(.ADDR_W(ADDR_W)) u_map (
    .kind     (kind_e'(req_kind)),
    .addr_in  (req_addr),
    .size_in  (req_size),
    .write_in (req_write),
    .mod_in   (req_mod),
    .upa_in   (req_upa),
    .cinh_in  (req_cinh),
    .addr_out (map_addr),
    .attr     (map_attr)
  );

  bae_lock_tracker u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .lockable (map_attr.lockable),
    .start    (req_lock_start),
    .last     (req_lock_last),
    .lock     (lk_now),
    .lock_end (lk_end_now)
  );

  always_comb begin
    next_attr.tt       = map_attr.tt;
    next_attr.tm       = map_attr.tm;
    next_attr.size     = map_attr.size;
    next_attr.write    = map_attr.write;
    next_attr.lock     = lk_now;
    next_attr.lock_end = lk_end_now;
    next_attr.upa      = map_attr.upa;
    next_attr.cinh     = map_attr.cinh;
  end

  bae_hold_stage #(.ADDR_W(ADDR_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .ack     (bus_ack),
    .addr_in (map_addr),
    .attr_in (next_attr),
    .busy    (busy),
    .addr_q  (bus_addr),
    .attr_q  (held_attr)
  );

  assign bus_req      = busy;
  assign bus_tt       = held_attr.tt;
  assign bus_tm       = held_attr.tm;
  assign bus_size     = held_attr.size;
  assign bus_write    = held_attr.write;
  assign bus_lock     = held_attr.lock;
  assign bus_lock_end = held_attr.lock_end;
  assign bus_upa      = held_attr.upa;
  assign bus_cinh     = held_attr.cinh;

endmodule

// File: rtl/bae_checker.sv
module bae_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_tt,
  input logic [2:0]        bus_tm,
  input logic [1:0]        bus_size,
  input logic              bus_write,
  input logic              bus_lock,
  input logic              bus_lock_end,
  input logic [1:0]        bus_upa,
  input logic              bus_cinh
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!bus_req && !bus_lock_end);
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_req);

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_tt)
      && $stable(bus_tm) && $stable(bus_size) && $stable(bus_write)
      && $stable(bus_lock) && $stable(bus_lock_end) && $stable(bus_upa)
      && $stable(bus_cinh));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);

  p_move_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_tt == 2'd1 |-> bus_size == 2'd3 && !bus_lock);

  p_alt_no_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_tt == 2'd2 |-> bus_size != 2'd3);

  p_ack_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_tt == 2'd3 |-> bus_size == 2'd1 && !bus_write && !bus_lock
      && bus_upa == 2'd0 && !bus_cinh);

  p_iack_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_tt == 2'd3 && bus_tm != 3'd0 |-> &bus_addr);

  p_bkpt_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_tt == 2'd3 && bus_tm == 3'd0 |-> bus_addr == '0);

  p_end_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock_end |-> bus_lock);

endmodule

bind bus_attr_encoder bae_checker #(.ADDR_W(ADDR_W)) u_bae_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .bus_req      (bus_req),
  .bus_ack      (bus_ack),
  .bus_addr     (bus_addr),
  .bus_tt       (bus_tt),
  .bus_tm       (bus_tm),
  .bus_size     (bus_size),
  .bus_write    (bus_write),
  .bus_lock     (bus_lock),
  .bus_lock_end (bus_lock_end),
  .bus_upa      (bus_upa),
  .bus_cinh     (bus_cinh)
);

// File: tb/tb_bus_attr_encoder.sv
`timescale 1ns/1ps
module tb_bus_attr_encoder;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_kind = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd0;
  logic          req_write = 1'b0;
  logic [2:0]    req_mod = 3'd0;
  logic [1:0]    req_upa = 2'd0;
  logic          req_cinh = 1'b0;
  logic          req_lock_start = 1'b0;
  logic          req_lock_last = 1'b0;
  logic          bus_req;
  logic          bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_tt;
  logic [2:0]    bus_tm;
  logic [1:0]    bus_size;
  logic          bus_write;
  logic          bus_lock;
  logic          bus_lock_end;
  logic [1:0]    bus_upa;
  logic          bus_cinh;

  always #2 clk = ~clk;

  bus_attr_encoder #(.ADDR_W(AW)) dut (.*);

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model state
  bit            m_busy, m_open;
  logic [AW-1:0] e_addr;
  int            e_tt, e_tm, e_size, e_wr, e_lk, e_le, e_upa, e_ci, e_kind;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0;
      m_open <= 0;
    end else if (m_busy) begin
      if (bus_ack) m_busy <= 0;
    end else if (req_valid) begin
      int  k;
      bit  lockable, lk;
      k = req_kind;
      e_kind <= k;
      e_addr <= req_addr;
      e_tm   <= req_mod;
      e_size <= req_size;
      e_wr   <= req_write;
      e_upa  <= 0;
      e_ci   <= 0;
      e_tt   <= 0;
      lockable = (k == 0 || k == 7 || k == 2 || k == 4);
      if (k == 0 || k == 7 || k == 3) begin
        e_upa <= req_upa;
        e_ci  <= req_cinh;
      end
      if (k == 1) begin e_tm <= 0; e_size <= 3; e_wr <= 1; end
      if (k == 2) e_size <= 0;
      if (k == 3) begin e_tt <= 1; e_size <= 3; end
      if (k == 4) begin e_tt <= 2; if (req_size == 2'd3) e_size <= 0; end
      if (k == 5) begin e_tt <= 3; e_addr <= '1; e_size <= 1; e_wr <= 0; end
      if (k == 6) begin e_tt <= 3; e_addr <= '0; e_size <= 1; e_wr <= 0; e_tm <= 0; end
      lk = lockable && (m_open || req_lock_start);
      e_lk <= lk;
      e_le <= lk && req_lock_last;
      if (lockable) m_open <= lk && !req_lock_last;
      m_busy <= 1;
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 bus_req", bus_req, 0);
      chk("R1 req_ready", req_ready, 1);
      chk("R1 bus_addr", bus_addr, 0);
      chk("R1 bus_lock", bus_lock, 0);
      chk("R1 bus_lock_end", bus_lock_end, 0);
    end else if (!done) begin
      chk("R2 bus_req", bus_req, m_busy);
      chk("R2 req_ready", req_ready, !m_busy);
      if (m_busy) begin
        string kt;
        case (e_kind)
          1: kt = "R8 ";
          4: kt = "R5 ";
          5: kt = "R6 ";
          6: kt = "R7 ";
          default: kt = "";
        endcase
        chk({kt, "R2 addr"}, bus_addr, e_addr);
        chk({kt, "R3 tt"}, bus_tt, e_tt);
        chk({kt, "R4 size"}, bus_size, e_size);
        chk({kt, "R13 tm"}, bus_tm, e_tm);
        chk({kt, "R10 write"}, bus_write, e_wr);
        chk({kt, "R11 lock"}, bus_lock, e_lk);
        chk({kt, "R12 lock_end"}, bus_lock_end, e_le);
        chk({kt, "R9 upa"}, bus_upa, e_upa);
        chk({kt, "R9 cinh"}, bus_cinh, e_ci);
      end
    end
  end

  // bus controller: acknowledge after a varying wait
  int ack_wait = 0;
  always @(negedge clk) begin
    if (rst_n && bus_req && !bus_ack) begin
      if (ack_wait == 0) begin
        bus_ack  <= 1'b1;
        ack_wait = $urandom % 4;
      end else begin
        ack_wait--;
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  // fields are driven at once, even while busy (exercises R2 hold)
  task automatic issue(input int kind, input logic [AW-1:0] addr, input int size,
                       input bit wr, input int md, input int upa, input bit ci,
                       input bit st, input bit ls);
    @(negedge clk);
    req_valid      = 1'b1;
    req_kind       = kind[2:0];
    req_addr       = addr;
    req_size       = size[1:0];
    req_write      = wr;
    req_mod        = md[2:0];
    req_upa        = upa[1:0];
    req_cinh       = ci;
    req_lock_start = st;
    req_lock_last  = ls;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 R4 R9 R10 R13 normal write word with page bits
    issue(0, 32'h1000_0002, 2, 1, 5, 2, 1, 0, 0);
    // R8 push overrides read/byte/modifier and page bits
    issue(1, 32'h2000_0010, 1, 0, 6, 3, 1, 0, 0);
    // R4 table search long
    issue(2, 32'h3000_0000, 1, 0, 4, 3, 1, 0, 0);
    // line move copies page bits
    issue(3, 32'h4000_0020, 0, 1, 1, 1, 1, 0, 0);
    // R5 alternate: line becomes long, byte kept
    issue(4, 32'h5000_0001, 3, 1, 7, 3, 1, 0, 0);
    issue(4, 32'h5000_0003, 1, 0, 2, 0, 0, 0, 0);
    // R6 interrupt acknowledge level 5, R7 breakpoint
    issue(5, 32'h1234_5678, 0, 1, 5, 3, 1, 0, 0);
    issue(6, 32'h8765_4321, 2, 1, 3, 3, 1, 0, 0);
    // R11 R12 locked sequence with non-lockable kinds inside
    issue(0, 32'h6000_0000, 0, 0, 1, 0, 0, 1, 0);
    issue(1, 32'h6000_0100, 3, 1, 0, 0, 0, 0, 1);
    issue(3, 32'h6000_0200, 3, 0, 1, 0, 0, 0, 1);
    issue(2, 32'h6000_0004, 0, 1, 1, 0, 0, 0, 0);
    issue(4, 32'h6000_0008, 0, 1, 1, 0, 0, 0, 1);
    // R12 last flag with no open sequence is ignored
    issue(0, 32'h7000_0000, 0, 1, 1, 0, 0, 0, 1);
    // single-transfer sequence
    issue(2, 32'h7000_0004, 0, 1, 1, 0, 0, 1, 1);
    issue(0, 32'h7000_0008, 0, 0, 1, 0, 0, 0, 0);
    // R2 mixed stream, including reserved code
    for (int i = 0; i < 400; i++) begin
      int k, md;
      k  = $urandom % 8;
      md = (k == 5) ? 1 + ($urandom % 7) : $urandom % 8;
      issue(k, $urandom, $urandom % 4, $urandom % 2, md, $urandom % 4,
            $urandom % 2, ($urandom % 6) == 0, ($urandom % 4) == 0);
    end
    while (bus_req) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule